// File: doc/BRIEF.md
# SDRAM refresh request scheduler

This block sits in front of a simple, non-bursting SDRAM controller and makes sure the controller receives auto-refresh requests often enough to keep the memory contents alive. The DRAM must see at least 4096 refreshes in any 64 ms, which means one refresh roughly every 15 us. An interval timer creates one refresh demand per period. The period in cycles is derived from the clock frequency (default 54 MHz) and the refresh spacing (default 15000 ns). Demands that the controller cannot take yet are kept in a saturating owed-refresh counter.

The controller only takes a refresh while its busy flag is low. It ignores a refresh raised while busy. When a read or write strobe is present in the same idle cycle, it serves the read or write first. The scheduler therefore holds its registered request high for as long as any refresh is owed. It counts a refresh as taken only when the request is high, busy is low, and neither user strobe is high in that cycle. After reset the controller is busy with power-up and configuration. The scheduler stays in a boot state during that time and starts timing intervals only once the controller first reports ready.

The sequencer has five states:
- **BOOT**: after reset, waiting for the first not-busy cycle. Leaves to CLEAR.
- **CLEAR**: nothing owed.
- **HOLD**: refreshes are owed and the controller was busy.
- **YIELD**: refreshes are owed and a user read or write took the idle slot.
- **OFFER**: refreshes are owed and the slot was free.

From CLEAR, HOLD, YIELD or OFFER, every clock edge moves to whichever of these four states matches the new owed count and the cycle's inputs.

Top module: `refresh_scheduler`

## Requirements
- R1: A low `rst_n` at a clock edge clears the interval timer, `owed_count`, `owed_overflow` and `refresh_req`, and returns the block to BOOT.
- R2: While in BOOT no demand is created. The block leaves BOOT at the first edge where `ctrl_busy` is low, and the interval timer starts from zero at that edge.
- R3: `refresh_req` is a register output that is high exactly when `owed_count` is non-zero, including while the controller is busy.
- R4: A refresh is accepted in a cycle where `refresh_req` is 1, `ctrl_busy` is 0, `user_rd` is 0 and `user_wr` is 0. Without a simultaneous demand, `owed_count` drops by one at the next edge.
- R5: A cycle with `user_rd` or `user_wr` high never accepts a refresh; the owed count is kept and no demand is lost.
- R6: `owed_count` saturates at PEND_MAX (default 8). A demand arriving while the count is full and no refresh is accepted sets `owed_overflow`, which stays set until reset.
- R7: A demand and an acceptance in the same cycle leave `owed_count` unchanged.
- R8: The interval is INTERVAL = (CLK_HZ/1000)·REFRESH_NS/1 000 000 cycles. With no traffic, the first request rises INTERVAL+1 cycles after the first not-busy cycle, and demands recur every INTERVAL cycles.
- R9: Under mixed read/write traffic with normal controller busy times (5 cycles per access, 4 per refresh), every window of 8·INTERVAL cycles contains at least 6 accepted refreshes and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_busy | input | 1 | Controller busy flag; a refresh is only taken while low |
| user_rd | input | 1 | User read strobe seen by the controller |
| user_wr | input | 1 | User write strobe seen by the controller |
| refresh_req | output | 1 | Registered refresh request to the controller |
| owed_count | output | $clog2(PEND_MAX+1) | Refreshes demanded but not yet accepted |
| owed_overflow | output | 1 | Sticky: a demand was dropped because the count was full |

## Verification
The bench builds the block with CLK_HZ = 125 000 000, REFRESH_NS = 200 and PEND_MAX = 4. This gives a 25-cycle interval and a ceiling of four owed refreshes. With these values the boot hold, saturation, the sticky overflow and many consecutive refresh windows under random traffic all fit in a few thousand cycles. A behavioural model of the scheduler and of the controller's busy timing runs alongside and is compared every cycle.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Sequencer states; see the brief for the transition rules.
    typedef enum logic [2:0] {
        SS_BOOT,
        SS_CLEAR,
        SS_HOLD,
        SS_YIELD,
        SS_OFFER
    } sched_state_t;

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int unsigned INTERVAL = 810
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R8: after a demand the period restarts from zero
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

    // R2: timer is held at zero while stopped
    a_r2_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
    parameter int unsigned PEND_MAX = 8,
    parameter int          PW       = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          accept,
    output logic [PW-1:0] owed,
    output logic          owed_next_nz,
    output logic          overflow
);
    localparam logic [PW-1:0] CEIL = PW'(PEND_MAX);

    logic [PW-1:0] owed_next;
    logic          ovf_next;

    always_comb begin
        owed_next = owed;
        ovf_next  = overflow;
        if (tick && !accept) begin
            if (owed == CEIL) begin
                ovf_next = 1'b1;
            end else begin
                owed_next = owed + 1'b1;
            end
        end else if (!tick && accept && (owed != '0)) begin
            owed_next = owed - 1'b1;
        end
    end

    assign owed_next_nz = (owed_next != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed     <= '0;
            overflow <= 1'b0;
        end else begin
            owed     <= owed_next;
            overflow <= ovf_next;
        end
    end

    // R6: count never passes the ceiling
    a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CEIL);

    // R6: overflow is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4: an acceptance without a demand takes one off
    a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tick) |=> (owed == $past(owed) - 1'b1));

    // R7: demand and acceptance together cancel
    a_r7_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tick) |=> $stable(owed));

endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd,
    input  logic wr,
    input  logic owed_next_nz,
    output logic run,
    output logic refresh_req,
    output logic accept
);
    sched_state_t state, state_next;

    // next-state logic
    always_comb begin
        state_next = state;
        unique case (state)
            SS_BOOT: begin
                state_next = busy ? SS_BOOT : SS_CLEAR;
            end
            SS_CLEAR, SS_HOLD, SS_YIELD, SS_OFFER: begin
                if (!owed_next_nz) begin
                    state_next = SS_CLEAR;
                end else if (busy) begin
                    state_next = SS_HOLD;
                end else if (rd || wr) begin
                    state_next = SS_YIELD;
                end else begin
                    state_next = SS_OFFER;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SS_BOOT;
        end else begin
            state <= state_next;
        end
    end

    // registered request output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_req <= 1'b0;
        end else begin
            refresh_req <= (state_next != SS_BOOT) && (state_next != SS_CLEAR);
        end
    end

    assign run    = (state != SS_BOOT);
    assign accept = refresh_req && !busy && !rd && !wr;

    // R2: nothing requested before the controller has come up
    a_r2_boot_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_BOOT) |-> !refresh_req);

    // R2: boot is left on the first not-busy cycle
    a_r2_boot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SS_BOOT) && !busy) |=> (state == SS_CLEAR));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int unsigned CLK_HZ     = 54_000_000,
    parameter int unsigned REFRESH_NS = 15_000,
    parameter int unsigned PEND_MAX   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ctrl_busy,
    input  logic                           user_rd,
    input  logic                           user_wr,
    output logic                           refresh_req,
    output logic [$clog2(PEND_MAX+1)-1:0]  owed_count,
    output logic                           owed_overflow
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam longint unsigned TICKS_L =
        (64'(CLK_HZ) / 64'd1000) * 64'(REFRESH_NS) / 64'd1_000_000;
    localparam int unsigned INTERVAL = 32'(TICKS_L);

    logic run;
    logic tick;
    logic accept;
    logic owed_next_nz;

    rfs_interval_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    rfs_owed_counter #(
        .PEND_MAX (PEND_MAX),
        .PW       (PW)
    ) u_owed (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .accept       (accept),
        .owed         (owed_count),
        .owed_next_nz (owed_next_nz),
        .overflow     (owed_overflow)
    );

    rfs_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (ctrl_busy),
        .rd           (user_rd),
        .wr           (user_wr),
        .owed_next_nz (owed_next_nz),
        .run          (run),
        .refresh_req  (refresh_req),
        .accept       (accept)
    );

    // R3: request mirrors a non-zero owed count
    a_r3_req_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req == (owed_count != '0));

    // R5: a user strobe keeps the owed count
    a_r5_yield: assert property (@(posedge clk) disable iff (!rst_n)
        ((user_rd || user_wr) && !tick) |=> (owed_count == $past(owed_count)));

    // R4: a busy controller takes nothing
    a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_busy && !tick) |=> (owed_count == $past(owed_count)));

endmodule

// File: tb/refresh_scheduler_test.sv
module refresh_scheduler_test;
    localparam int CLK_HZ = 125_000_000;
    localparam int REF_NS = 200;
    localparam int PMAX   = 4;
    localparam int N      = 25;
    localparam int PW     = 3;
    localparam int WIN    = 8 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b1;
    logic rd = 1'b0;
    logic wr = 1'b0;
    wire          req;
    wire [PW-1:0] cnt;
    wire          ovf;

    always #4 clk = ~clk;

    refresh_scheduler #(
        .CLK_HZ     (CLK_HZ),
        .REFRESH_NS (REF_NS),
        .PEND_MAX   (PMAX)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_busy     (busy),
        .user_rd       (rd),
        .user_wr       (wr),
        .refresh_req   (req),
        .owed_count    (cnt),
        .owed_overflow (ovf)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int r_p = 0;
    int r_tmr = 0;
    bit r_boot = 1;
    bit r_ovf = 0;
    bit r_req = 0;
    // controller model
    int ctl_cnt = 0;
    bit boot_hold = 1;
    bit force_busy = 0;
    int acc_seen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit nrst, input bit nrd, input bit nwr);
        bit acc, tick;
        @(negedge clk);
        chk(req === r_req, "R3 request", int'(req), int'(r_req));
        chk(cnt === PW'(r_p), "R4 owed count", int'(cnt), r_p);
        chk(ovf === r_ovf, "R6 overflow", int'(ovf), int'(r_ovf));
        rst_n = nrst;
        rd = nrd;
        wr = nwr;
        busy = boot_hold | force_busy | (ctl_cnt != 0);
        if (req && !busy && !rd && !wr && rst_n) acc_seen++;
        if (!rst_n) begin
            r_p = 0; r_tmr = 0; r_boot = 1; r_ovf = 0; r_req = 0;
        end else begin
            acc = r_req && !busy && !rd && !wr;
            if (r_boot) begin
                if (!busy) r_boot = 0;
            end else begin
                tick = (r_tmr == N - 1);
                r_tmr = tick ? 0 : r_tmr + 1;
                if (tick && !acc) begin
                    if (r_p == PMAX) r_ovf = 1;
                    else r_p++;
                end else if (!tick && acc) begin
                    r_p--;
                end
            end
            r_req = !r_boot && (r_p != 0);
        end
        if (!busy && (rd || wr)) ctl_cnt = 5;
        else if (!busy && req) ctl_cnt = 4;
        else if (ctl_cnt > 0) ctl_cnt--;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k, a0, lvl;
        repeat (4) step(0, 0, 0);
        // R1 reset state
        chk(req == 0 && cnt == 0 && ovf == 0, "R1 reset outputs", int'(cnt), 0);

        // R2 boot hold: no demand while controller busy
        repeat (300) step(1, 0, 0);
        chk(cnt == 0, "R2 no demand in boot", int'(cnt), 0);
        chk(req == 0, "R2 no request in boot", int'(req), 0);

        // R8 first request timing after release
        boot_hold = 0;
        k = 0;
        while (!req && k < 1000) begin
            step(1, 0, 0);
            k++;
        end
        chk(k == N + 2, "R8 first request delay", k - 1, N + 1);

        repeat (150) step(1, 0, 0);
        chk(ovf == 0, "R8 idle no overflow", int'(ovf), 0);

        // R6 saturation under a stuck busy
        force_busy = 1;
        repeat ((PMAX + 2) * N) step(1, 0, 0);
        chk(cnt == PMAX, "R6 saturated count", int'(cnt), PMAX);
        chk(ovf == 1, "R6 overflow set", int'(ovf), 1);
        chk(req == 1, "R3 request held while busy", int'(req), 1);
        force_busy = 0;
        repeat (60) step(1, 0, 0);
        chk(ovf == 1, "R6 overflow sticky", int'(ovf), 1);

        // R5 continuous writes: nothing accepted, demands kept
        lvl = int'(cnt);
        a0 = acc_seen;
        repeat (3 * N) step(1, 0, 1);
        chk(acc_seen == a0, "R5 no accept under writes", acc_seen - a0, 0);
        chk(int'(cnt) >= 2, "R5 demands retained", int'(cnt), 2);
        repeat (40) step(1, 0, 0);
        chk(acc_seen > a0, "R4 backlog drained", acc_seen - a0, 1);

        // R1 mid-run reset clears overflow and count
        boot_hold = 1;
        repeat (2) step(0, 0, 0);
        chk(ovf == 0 && cnt == 0 && req == 0, "R1 mid-run reset", int'(ovf), 0);
        repeat (20) step(1, 0, 0);
        boot_hold = 0;
        repeat (30) step(1, 0, 0);

        // R9 random traffic, per-window acceptance floor
        for (int w = 0; w < 20; w++) begin
            a0 = acc_seen;
            for (int c = 0; c < WIN; c++) begin
                step(1, ($urandom % 100) < 15, ($urandom % 100) < 10);
            end
            chk(acc_seen - a0 >= 6, "R9 refreshes per window", acc_seen - a0, 6);
        end
        chk(ovf == 0, "R9 no overflow under traffic", int'(ovf), 0);
        if (lvl < 0) $display("unreachable");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule